// File: doc/BRIEF.md
# Asynchronous Parallel Host-Bus Slave Interface

This block is the slave end of an asynchronous 16-bit parallel bus driven by a microcontroller-style host. The host supplies an active-low select, write strobe and read strobe, along with an address, an active-low high-byte enable and a data bus. The block samples the three strobes into its own clock domain and turns each host access into exactly one word access on a synchronous request/acknowledge memory port. Writes are posted when the write strobe rises. Reads are launched when the read strobe falls. A BUSY flag holds the host off while an internal access is running.

The host pins are modelled without tristates. Each driven output has a separate output enable: the data bus has one, and so does BUSY. BUSY is driven whenever select is asserted, and it is released at once when select goes away, even if an internal access is still running. A read that lands while a posted write is still in flight waits behind that write. BUSY stays high across both accesses and falls in the same cycle that the read data is loaded. A write strobe rising edge that arrives while the block is busy is a host protocol violation. It is flagged on a one-cycle error pulse and the write is discarded.

The controller has four states. ST_IDLE has no access running. ST_WRITE runs a posted write. ST_WRITE_RDQ runs a posted write with a read queued behind it. ST_READ runs a read. The transitions are as follows:
- IDLE→WRITE on an accepted write edge.
- IDLE→READ on a read edge.
- IDLE→WRITE_RDQ when both edges are seen in the same cycle.
- WRITE→WRITE_RDQ on a read edge before the acknowledge.
- WRITE→READ when the acknowledge and a read edge coincide.
- WRITE→IDLE on the acknowledge.
- WRITE_RDQ→READ on the acknowledge.
- READ→IDLE on the acknowledge.

Top module: `hbus_slave`

## Requirements
- R1: After reset, mem_req and host_proto_err are 0, host_busy is 0, and with host_sel_n high host_busy_oe and host_data_oe are 0.
- R2: A write is launched only on the rising edge of host_wr_n while select is asserted. No memory request appears while host_wr_n is low. Address, high-byte enable and data are captured when the rising edge is detected, so the host holds them for 3 clocks after the rising edge.
- R3: Every access uses word address host_addr[AW-1:1] and byte enables mem_be = {~host_bhe_n, ~host_addr[0]}, where bit 1 is the upper byte [15:8] and bit 0 is the lower byte [7:0]. A write changes only the enabled bytes.
- R4: host_busy reads 1 by the third rising clock edge after a host_wr_n rising edge or a host_rd_n falling edge. It stays 1 until the internal access completes.
- R5: host_busy_oe follows select asserted. When select is deasserted during an internal write, BUSY is released while the write still completes.
- R6: A host_wr_n rising edge with select asserted while the block is busy raises host_proto_err for one cycle, and that write is discarded.
- R7: A read starts on the falling edge of host_rd_n, latching the address and high-byte enable. host_data_out holds the read word when host_busy falls.
- R8: A read edge during a pending posted write is served after that write. BUSY stays 1 across both accesses, and the returned data reflects the write.
- R9: host_data_oe is 1 only while both host_sel_n and host_rd_n are low.
- R10: Strobe edges seen while select is deasserted start no access and raise no error.
- R11: mem_req stays high until mem_ack, with mem_addr, mem_we, mem_be and mem_wdata stable. Any acknowledge latency from 1 to 8 cycles is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel_n | input | 1 | Host chip select, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr | input | AW | Host byte address |
| host_bhe_n | input | 1 | High-byte enable, active low |
| host_data_in | input | 16 | Data from host |
| host_data_out | output | 16 | Read data to host |
| host_data_oe | output | 1 | Data bus drive enable |
| host_busy | output | 1 | BUSY value, active high |
| host_busy_oe | output | 1 | BUSY drive enable |
| host_proto_err | output | 1 | One-cycle pulse on a write during busy |
| mem_req | output | 1 | Internal access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW-1 | Internal word address |
| mem_be | output | 2 | Byte enables, bit 1 = upper byte |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | One-cycle completion pulse |
| mem_rdata | input | 16 | Read data, valid with mem_ack |

## Verification
The hardest case to reach from the ports is a read strobe that falls while a posted write is still waiting for its acknowledge. Only in that case is the read queued, and BUSY must stay high across both accesses. The bench sets the memory model's acknowledge latency to its maximum and starts a write. Once BUSY is seen high, it drops the read strobe on the same word. The returned word can only equal the freshly written value if the write went first, and BUSY must not fall before that word appears. The same long latency is used to land a second write edge inside the busy window and to pull select away mid-write. A sweep over all latencies, eight words and the four byte-lane combinations covers the lane logic.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int DW = 16;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITE     = 2'd1,
        ST_WRITE_RDQ = 2'd2,
        ST_READ      = 2'd3
    } hb_state_t;

    // bit 1: upper byte lane, bit 0: lower byte lane
    function automatic logic [1:0] lane_en(input logic a0, input logic bhe_n);
        return {~bhe_n, ~a0};
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[b];
                stab_q <= RST_VAL[b];
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end

endmodule

// File: rtl/hbus_fsm.sv
module hbus_fsm
    import hbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_s,      // synchronised select, active low
    input  logic wr_s,       // synchronised write strobe, active low
    input  logic rd_s,       // synchronised read strobe, active low
    input  logic mem_ack,
    output logic wr_cap_o,
    output logic rd_cap_o,
    output logic req_o,
    output logic we_o,
    output logic busy_o,
    output logic rd_load_o,
    output logic err_o
);

    hb_state_t state_q;
    hb_state_t state_d;
    logic      wr_prev_q;
    logic      rd_prev_q;
    logic      err_q;
    logic      wr_rise;
    logic      rd_fall;
    logic      err_d;

    assign wr_rise = wr_s & ~wr_prev_q & ~sel_s;
    assign rd_fall = ~rd_s & rd_prev_q & ~sel_s;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wr_prev_q <= 1'b1;
            rd_prev_q <= 1'b1;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            wr_prev_q <= wr_s;
            rd_prev_q <= rd_s;
            err_q     <= err_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_rise && rd_fall) state_d = ST_WRITE_RDQ;
                else if (wr_rise)       state_d = ST_WRITE;
                else if (rd_fall)       state_d = ST_READ;
            end
            ST_WRITE: begin
                if (mem_ack)      state_d = rd_fall ? ST_READ : ST_IDLE;
                else if (rd_fall) state_d = ST_WRITE_RDQ;
            end
            ST_WRITE_RDQ: begin
                if (mem_ack) state_d = ST_READ;
            end
            ST_READ: begin
                if (mem_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_cap_o  = 1'b0;
        rd_cap_o  = 1'b0;
        req_o     = 1'b0;
        we_o      = 1'b0;
        rd_load_o = 1'b0;
        err_d     = wr_rise && (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: begin
                wr_cap_o = wr_rise;
                rd_cap_o = rd_fall;
            end
            ST_WRITE: begin
                req_o    = 1'b1;
                we_o     = 1'b1;
                rd_cap_o = rd_fall;
            end
            ST_WRITE_RDQ: begin
                req_o = 1'b1;
                we_o  = 1'b1;
            end
            ST_READ: begin
                req_o     = 1'b1;
                rd_load_o = mem_ack;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE);
    assign err_o  = err_q;

    AST_ERR_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($past(state_q) != ST_IDLE)); // R6

    AST_QUEUED_READ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WRITE_RDQ && mem_ack) |=> (state_q == ST_READ && busy_o)); // R8

    AST_READ_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && mem_ack) |=> !busy_o); // R7

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int AW = 8,
    localparam int WAW = AW - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel_n,
    input  logic           host_wr_n,
    input  logic           host_rd_n,
    input  logic [AW-1:0]  host_addr,
    input  logic           host_bhe_n,
    input  logic [DW-1:0]  host_data_in,
    output logic [DW-1:0]  host_data_out,
    output logic           host_data_oe,
    output logic           host_busy,
    output logic           host_busy_oe,
    output logic           host_proto_err,
    output logic           mem_req,
    output logic           mem_we,
    output logic [WAW-1:0] mem_addr,
    output logic [1:0]     mem_be,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);

    logic [2:0]    strobes_s;
    logic          wr_cap;
    logic          rd_cap;
    logic          we_sel;
    logic          rd_load;
    logic          busy;
    logic [AW-1:0] wr_addr_q;
    logic          wr_bhe_q;
    logic [DW-1:0] wr_data_q;
    logic [AW-1:0] rd_addr_q;
    logic          rd_bhe_q;
    logic [DW-1:0] rd_data_q;

    hbus_sync #(.W(3), .RST_VAL(3'b111)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({host_sel_n, host_wr_n, host_rd_n}),
        .sync_o  (strobes_s)
    );

    hbus_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_s     (strobes_s[2]),
        .wr_s      (strobes_s[1]),
        .rd_s      (strobes_s[0]),
        .mem_ack   (mem_ack),
        .wr_cap_o  (wr_cap),
        .rd_cap_o  (rd_cap),
        .req_o     (mem_req),
        .we_o      (we_sel),
        .busy_o    (busy),
        .rd_load_o (rd_load),
        .err_o     (host_proto_err)
    );

    // capture registers, held until the access completes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            wr_bhe_q  <= 1'b1;
            wr_data_q <= '0;
            rd_addr_q <= '0;
            rd_bhe_q  <= 1'b1;
            rd_data_q <= '0;
        end else begin
            if (wr_cap) begin
                wr_addr_q <= host_addr;
                wr_bhe_q  <= host_bhe_n;
                wr_data_q <= host_data_in;
            end
            if (rd_cap) begin
                rd_addr_q <= host_addr;
                rd_bhe_q  <= host_bhe_n;
            end
            if (rd_load) begin
                rd_data_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        mem_we    = we_sel;
        mem_wdata = wr_data_q;
        if (we_sel) begin
            mem_addr = wr_addr_q[AW-1:1];
            mem_be   = lane_en(wr_addr_q[0], wr_bhe_q);
        end else begin
            mem_addr = rd_addr_q[AW-1:1];
            mem_be   = lane_en(rd_addr_q[0], rd_bhe_q);
        end
    end

    assign host_busy     = busy;
    assign host_busy_oe  = ~host_sel_n;
    assign host_data_out = rd_data_q;
    assign host_data_oe  = ~host_sel_n & ~host_rd_n;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req); // R11

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_be) && $stable(mem_wdata))); // R11

    AST_REQ_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> host_busy); // R4

endmodule

// File: tb/test_hbus_slave.sv
module test_hbus_slave;

    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_sel_n = 1'b1;
    logic          host_wr_n = 1'b1;
    logic          host_rd_n = 1'b1;
    logic [AW-1:0] host_addr = '0;
    logic          host_bhe_n = 1'b1;
    logic [15:0]   host_data_in = '0;
    logic [15:0]   host_data_out;
    logic          host_data_oe;
    logic          host_busy;
    logic          host_busy_oe;
    logic          host_proto_err;
    logic          mem_req;
    logic          mem_we;
    logic [AW-2:0] mem_addr;
    logic [1:0]    mem_be;
    logic [15:0]   mem_wdata;
    logic          mem_ack;
    logic [15:0]   mem_rdata;

    int checks = 0;
    int errors = 0;
    int lat_cfg = 1;
    int mcnt = 0;
    logic [15:0] mem [128];
    logic [15:0] exp_mem [128];

    always #4 clk = ~clk;

    hbus_slave #(.AW(AW)) i_hbus_slave (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_wr_n(host_wr_n),
        .host_rd_n(host_rd_n), .host_addr(host_addr), .host_bhe_n(host_bhe_n),
        .host_data_in(host_data_in), .host_data_out(host_data_out),
        .host_data_oe(host_data_oe), .host_busy(host_busy), .host_busy_oe(host_busy_oe),
        .host_proto_err(host_proto_err), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model with run-time latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mcnt      <= 0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            if (mcnt >= lat_cfg - 1) begin
                mem_ack <= 1'b1;
                mcnt    <= 0;
                if (mem_we) begin
                    if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
                    if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
                end
                mem_rdata <= mem[mem_addr];
            end else begin
                mcnt <= mcnt + 1;
            end
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_free();
        for (int k = 0; k < 60 && host_busy; k++) @(negedge clk);
        chk(!host_busy, "R4 busy clears after access", {31'd0, host_busy}, 32'd0);
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                          input logic a0, input logic bhe_n);
        logic [15:0] r = old;
        if (!a0)    r[7:0]  = d[7:0];
        if (!bhe_n) r[15:8] = d[15:8];
        return r;
    endfunction

    task automatic host_write(input logic [AW-1:0] a, input logic bhe_n, input logic [15:0] d);
        @(negedge clk);
        host_sel_n = 1'b0; host_addr = a; host_bhe_n = bhe_n; host_data_in = d; host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req == 1'b0, "R2 no request while WR low", {31'd0, mem_req}, 32'd0);
        host_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(host_busy && host_busy_oe, "R4 busy after WR rise", {30'd0, host_busy, host_busy_oe}, 32'd3);
        wait_free();
        @(negedge clk);
        host_sel_n = 1'b1;
        exp_mem[a[AW-1:1]] = merge(exp_mem[a[AW-1:1]], d, a[0], bhe_n);
    endtask

    task automatic host_read(input logic [AW-1:0] a, input logic bhe_n, input string tag);
        @(negedge clk);
        host_sel_n = 1'b0; host_addr = a; host_bhe_n = bhe_n; host_rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(host_busy, "R4 busy after RD fall", {31'd0, host_busy}, 32'd1);
        wait_free();
        chk(host_data_oe && host_data_out == exp_mem[a[AW-1:1]], tag,
            {15'd0, host_data_oe, host_data_out}, {16'd1, exp_mem[a[AW-1:1]]});
        host_rd_n = 1'b1;
        @(negedge clk);
        host_sel_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", checks);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!mem_req && !host_proto_err && !host_busy && !host_busy_oe && !host_data_oe,
            "R1 reset outputs", {27'd0, mem_req, host_proto_err, host_busy, host_busy_oe, host_data_oe}, 32'd0);

        // R3 R7 R11 sweep over latency, words and byte lanes
        for (int lat = 1; lat <= 8; lat++) begin
            lat_cfg = lat;
            for (int w = 0; w < 8; w++) begin
                logic [15:0] d = 16'((w * 16'h1357 + lat * 16'h0101) ^ 16'hA5C3);
                host_write(AW'(w * 2), 1'b0, d);
                host_read(AW'(w * 2), 1'b0, "R7 R11 full word readback");
                for (int m = 1; m < 4; m++) begin
                    logic [15:0] d2 = ~d + 16'(m * 16'h0F1E);
                    host_write(AW'(w * 2 + (m & 1)), 1'(m >> 1), d2);
                    host_read(AW'(w * 2), 1'b0, "R3 byte lane write readback");
                end
            end
        end

        // R5 release BUSY mid-write, write still completes
        lat_cfg = 8;
        @(negedge clk);
        host_sel_n = 1'b0; host_addr = 8'h20; host_bhe_n = 1'b0; host_data_in = 16'hBEEF; host_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        host_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        host_sel_n = 1'b1;
        #1;
        chk(!host_busy_oe && mem_req, "R5 busy released while write runs",
            {30'd0, host_busy_oe, mem_req}, 32'd1);
        for (int k = 0; k < 40 && mem_req; k++) @(negedge clk);
        exp_mem[8'h10] = 16'hBEEF;
        host_read(8'h20, 1'b0, "R5 released write completed");

        // R8 read queued behind pending write
        begin
            int cnt = 0;
            @(negedge clk);
            host_sel_n = 1'b0; host_addr = 8'h22; host_bhe_n = 1'b0; host_data_in = 16'h6A5C; host_wr_n = 1'b0;
            repeat (2) @(negedge clk);
            host_wr_n = 1'b1;
            repeat (3) @(negedge clk);
            chk(host_busy, "R8 write pending", {31'd0, host_busy}, 32'd1);
            host_rd_n = 1'b0;
            for (int k = 0; k < 60 && host_busy; k++) begin @(negedge clk); cnt++; end
            chk(host_data_out == 16'h6A5C && !host_busy, "R8 queued read sees write data",
                {15'd0, host_busy, host_data_out}, 32'h6A5C);
            chk(cnt >= 9, "R8 busy continuous across both accesses", cnt, 9);
            host_rd_n = 1'b1;
            @(negedge clk);
            host_sel_n = 1'b1;
            exp_mem[8'h11] = 16'h6A5C;
        end

        // R6 write while busy is flagged and discarded
        begin
            bit seen = 1'b0;
            @(negedge clk);
            host_sel_n = 1'b0; host_addr = 8'h24; host_bhe_n = 1'b0; host_data_in = 16'h1111; host_wr_n = 1'b0;
            repeat (2) @(negedge clk);
            host_wr_n = 1'b1;
            repeat (3) @(negedge clk);
            host_data_in = 16'h2222; host_wr_n = 1'b0;
            @(negedge clk);
            host_wr_n = 1'b1;
            for (int k = 0; k < 40; k++) begin @(negedge clk); if (host_proto_err) seen = 1'b1; end
            chk(seen, "R6 protocol error flagged", {31'd0, seen}, 32'd1);
            host_sel_n = 1'b1;
            exp_mem[8'h12] = 16'h1111;
            host_read(8'h24, 1'b0, "R6 second write discarded");
        end

        // R10 strobes ignored with select deasserted
        begin
            bit any = 1'b0;
            @(negedge clk);
            host_addr = 8'h26; host_data_in = 16'h7777; host_wr_n = 1'b0;
            repeat (2) @(negedge clk);
            host_wr_n = 1'b1;
            host_rd_n = 1'b0;
            // R9 data bus not driven with select high
            chk(!host_data_oe, "R9 no drive without select", {31'd0, host_data_oe}, 32'd0);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (mem_req || host_proto_err || host_busy) any = 1'b1;
            end
            chk(!any, "R10 no access without select", {31'd0, any}, 32'd0);
            host_rd_n = 1'b1;
            @(negedge clk);
            host_sel_n = 1'b0;
            @(negedge clk);
            chk(!host_data_oe && host_busy_oe, "R9 no drive without RD",
                {30'd0, host_data_oe, host_busy_oe}, 32'd1);
            host_sel_n = 1'b1;
            host_read(8'h26, 1'b0, "R10 ignored write left word intact");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule